// File: doc/BRIEF.md
# Picture-in-Picture Window Timing Generator

This block decides, pixel by pixel, where a small inset picture sits on top of the main picture. It counts sample clocks from the main horizontal sync and lines from the main vertical sync. It compares both counts with a programmable window origin and sizes the window for a one-ninth or one-sixteenth reduction, chosen separately for each axis. The result is a registered switch that selects the inset over the main picture, plus flags that mark border pixels and pixels to be filled with a flat background colour.

The vertical origin can be stretched by a factor of 1.2 when the main picture runs at 50 Hz. The block tells 50 Hz from 60 Hz by the number of lines in the previous field. It also reports the parity of the main field, taken from where the vertical sync edge lands within a line. Software can invert that parity or force it to a fixed value. One sample is processed per clock.

Top module: `pip_window_gen`

## Requirements
- R1: While `rstN` is low and on the first sample after release, `pipSwitch`, `borderSel`, `bgSel` and `fieldOdd` are 0.
- R2: The pixel index is 0 on the clock where a rising `hsync` is sampled and then counts up by one per clock. The line index is 0 after a rising `vsync` and goes up by one at each rising `hsync`. `pipSwitch` is 1 exactly one clock after a pixel whose index lies in [hStart, hStart+width) and whose line lies in [vStart, vStart+height), provided `dispEn` is 1.
- R3: The window height is `WIN_H9` lines (69 by default) when `sizeV`=0 and `WIN_H16` lines (52) when `sizeV`=1.
- R4: The window width is `WIN_W9` samples (229 by default) when `sizeH`=0 and `WIN_W16` samples (172) when `sizeH`=1.
- R5: With `dispEn`=0, `pipSwitch`, `borderSel` and `bgSel` stay 0 whatever the other controls are.
- R6: With `frameEn`=1, `borderSel` is 1 for window pixels on the first or last window line, or within `BORDER_W` (2) samples of the left or right window edge. `pipSwitch` stays 1 on those pixels.
- R7: With `bgEn`=1, `bgSel` is 1 on every window pixel that is not a border pixel. `bgSel` and `borderSel` are never 1 together.
- R8: When `posMode`=1 and the previous field held at least `FIELD50_MIN` lines, vStart is floor(`vPos`×1.2). Otherwise vStart is `vPos`.
- R9: `fieldOdd` becomes 1 when the rising `vsync` is sampled at a pixel index below half the previous line's length, and 0 otherwise.
- R10: `invField`=1 inverts the reported parity. `fieldFix`=1 makes `fieldOdd` follow `fieldFixVal`, one clock later.
- R11: A window that runs past the next `hsync` or `vsync` is cut there. Pixels after the new sync edge fall outside the window unless they lie inside it by their own indices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Active-low synchronous reset |
| hsync | input | 1 | Main horizontal sync, rising edge starts a line |
| vsync | input | 1 | Main vertical sync, rising edge starts a field |
| dispEn | input | 1 | Enables the window |
| frameEn | input | 1 | Enables the border |
| bgEn | input | 1 | Selects flat background fill inside the window |
| sizeV | input | 1 | Vertical size: 0 one-ninth, 1 one-sixteenth |
| sizeH | input | 1 | Horizontal size: 0 one-ninth, 1 one-sixteenth |
| posMode | input | 1 | Enables 1.2× vertical origin at 50 Hz |
| invField | input | 1 | Inverts field parity |
| fieldFix | input | 1 | Forces field parity |
| fieldFixVal | input | 1 | Parity value used when forced |
| vPos | input | 8 | Vertical window origin in lines |
| hPos | input | 8 | Horizontal window origin in samples |
| pipSwitch | output | 1 | Inset select, registered |
| borderSel | output | 1 | Border pixel flag, registered |
| bgSel | output | 1 | Background fill flag, registered |
| fieldOdd | output | 1 | Main field parity, 1 for odd |

## Verification
The assertions assume that the window controls, and `hPos` in particular, change only while the window is inactive. In practice that means outside a line's active span, never on the clock after a sync edge. The bench changes every control between fields, at a falling clock edge while the sync lines are low. It also assumes each sync pulse is short compared with a line. The bench drives one-clock `hsync` pulses and a one-clock `vsync` pulse placed inside a line, never on the same clock as `hsync`. The bench shrinks the window sizes and the 50 Hz line threshold through parameters, so that whole fields fit in a short run.

// File: rtl/pip_win_pkg.sv
package pip_win_pkg;

  // Sync strobes passed from control to datapath
  typedef struct packed {
    logic hEdge;  // rising edge of main horizontal sync
    logic vEdge;  // rising edge of main vertical sync
  } pip_strobe_t;

endpackage

// File: rtl/pip_win_ctrl.sv
module pip_win_ctrl
  import pip_win_pkg::*;
#(
  parameter int PIX_W       = 11,
  parameter int LINE_W      = 10,
  parameter int FIELD50_MIN = 288
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hsync,
  input  logic              vsync,
  input  logic              posMode,
  input  logic              invField,
  input  logic              fieldFix,
  input  logic              fieldFixVal,
  input  logic [7:0]        vPos,
  input  logic [PIX_W-1:0]  pixCnt,
  input  logic [PIX_W-1:0]  lineLen,
  input  logic [LINE_W-1:0] lineCnt,
  output pip_strobe_t       stb,
  output logic [LINE_W-1:0] vStartEff,
  output logic              fieldOdd
);

  localparam int SCL_W = 11;  // wide enough for 255*6

  logic hsQ, vsQ;
  logic is50;
  logic rawOdd;
  logic [SCL_W-1:0] prod6;
  logic [SCL_W-1:0] scaled;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hsQ <= 1'b0;
      vsQ <= 1'b0;
    end else begin
      hsQ <= hsync;
      vsQ <= vsync;
    end
  end

  assign stb.hEdge = hsync & ~hsQ;
  assign stb.vEdge = vsync & ~vsQ;

  // Field rate and parity are both judged at the vertical edge
  always_ff @(posedge clk) begin
    if (!rstN) begin
      is50   <= 1'b0;
      rawOdd <= 1'b0;
    end else if (stb.vEdge) begin
      is50   <= (lineCnt >= LINE_W'(FIELD50_MIN));
      rawOdd <= (pixCnt < (lineLen >> 1));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) fieldOdd <= 1'b0;
    else       fieldOdd <= fieldFix ? fieldFixVal : (rawOdd ^ invField);
  end

  // 1.2x origin: multiply by six, divide by five
  assign prod6  = SCL_W'(vPos) * SCL_W'(6);
  assign scaled = prod6 / SCL_W'(5);

  assign vStartEff = (posMode && is50) ? LINE_W'(scaled) : LINE_W'(vPos);

endmodule

// File: rtl/pip_win_dp.sv
module pip_win_dp
  import pip_win_pkg::*;
#(
  parameter int PIX_W    = 11,
  parameter int LINE_W   = 10,
  parameter int WIN_W9   = 229,
  parameter int WIN_W16  = 172,
  parameter int WIN_H9   = 69,
  parameter int WIN_H16  = 52,
  parameter int BORDER_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  pip_strobe_t       stb,
  input  logic [LINE_W-1:0] vStart,
  input  logic [7:0]        hPos,
  input  logic              sizeV,
  input  logic              sizeH,
  input  logic              dispEn,
  input  logic              frameEn,
  input  logic              bgEn,
  output logic [PIX_W-1:0]  pixCnt,
  output logic [PIX_W-1:0]  lineLen,
  output logic [LINE_W-1:0] lineCnt,
  output logic              pipSwitch,
  output logic              borderSel,
  output logic              bgSel
);

  localparam logic [PIX_W-1:0]  PIX_MAX  = '1;
  localparam logic [LINE_W-1:0] LINE_MAX = '1;

  logic [PIX_W-1:0]  hStart, hEnd, winW;
  logic [LINE_W-1:0] vEnd, winH;
  logic inH, inV, inWin;
  logic edgeH, edgeV, onBorder;

  // Counters saturate so a missing sync never wraps into the window
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pixCnt  <= '0;
      lineLen <= '0;
    end else if (stb.hEdge) begin
      pixCnt  <= '0;
      lineLen <= (pixCnt == PIX_MAX) ? pixCnt : pixCnt + 1'b1;
    end else if (pixCnt != PIX_MAX) begin
      pixCnt  <= pixCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                              lineCnt <= '0;
    else if (stb.vEdge)                     lineCnt <= '0;
    else if (stb.hEdge && lineCnt != LINE_MAX) lineCnt <= lineCnt + 1'b1;
  end

  assign winW   = sizeH ? PIX_W'(WIN_W16) : PIX_W'(WIN_W9);
  assign winH   = sizeV ? LINE_W'(WIN_H16) : LINE_W'(WIN_H9);
  assign hStart = PIX_W'(hPos);
  assign hEnd   = hStart + winW;
  assign vEnd   = vStart + winH;

  assign inH   = (pixCnt >= hStart) && (pixCnt < hEnd);
  assign inV   = (lineCnt >= vStart) && (lineCnt < vEnd);
  assign inWin = inH && inV;

  assign edgeV = (lineCnt == vStart) || (lineCnt == vEnd - 1'b1);

  generate
    if (BORDER_W > 0) begin : g_sideBorder
      assign edgeH = (pixCnt < hStart + PIX_W'(BORDER_W)) ||
                     (pixCnt >= hEnd - PIX_W'(BORDER_W));
    end else begin : g_noSideBorder
      assign edgeH = 1'b0;
    end
  endgenerate

  assign onBorder = frameEn && (edgeH || edgeV);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pipSwitch <= 1'b0;
      borderSel <= 1'b0;
      bgSel     <= 1'b0;
    end else begin
      pipSwitch <= dispEn && inWin;
      borderSel <= dispEn && inWin && onBorder;
      bgSel     <= dispEn && inWin && bgEn && !onBorder;
    end
  end

endmodule

// File: rtl/pip_window_gen.sv
module pip_window_gen
  import pip_win_pkg::*;
#(
  parameter int PIX_W       = 11,
  parameter int LINE_W      = 10,
  parameter int WIN_W9      = 229,
  parameter int WIN_W16     = 172,
  parameter int WIN_H9      = 69,
  parameter int WIN_H16     = 52,
  parameter int BORDER_W    = 2,
  parameter int FIELD50_MIN = 288
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hsync,
  input  logic       vsync,
  input  logic       dispEn,
  input  logic       frameEn,
  input  logic       bgEn,
  input  logic       sizeV,
  input  logic       sizeH,
  input  logic       posMode,
  input  logic       invField,
  input  logic       fieldFix,
  input  logic       fieldFixVal,
  input  logic [7:0] vPos,
  input  logic [7:0] hPos,
  output logic       pipSwitch,
  output logic       borderSel,
  output logic       bgSel,
  output logic       fieldOdd
);

  pip_strobe_t       stb;
  logic [LINE_W-1:0] vStartEff;
  logic [PIX_W-1:0]  pixCnt;
  logic [PIX_W-1:0]  lineLen;
  logic [LINE_W-1:0] lineCnt;

  pip_win_ctrl #(
    .PIX_W(PIX_W), .LINE_W(LINE_W), .FIELD50_MIN(FIELD50_MIN)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .hsync(hsync), .vsync(vsync),
    .posMode(posMode), .invField(invField), .fieldFix(fieldFix),
    .fieldFixVal(fieldFixVal), .vPos(vPos), .pixCnt(pixCnt),
    .lineLen(lineLen), .lineCnt(lineCnt), .stb(stb),
    .vStartEff(vStartEff), .fieldOdd(fieldOdd)
  );

  pip_win_dp #(
    .PIX_W(PIX_W), .LINE_W(LINE_W), .WIN_W9(WIN_W9), .WIN_W16(WIN_W16),
    .WIN_H9(WIN_H9), .WIN_H16(WIN_H16), .BORDER_W(BORDER_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .vStart(vStartEff), .hPos(hPos),
    .sizeV(sizeV), .sizeH(sizeH), .dispEn(dispEn), .frameEn(frameEn),
    .bgEn(bgEn), .pixCnt(pixCnt), .lineLen(lineLen), .lineCnt(lineCnt),
    .pipSwitch(pipSwitch), .borderSel(borderSel), .bgSel(bgSel)
  );

endmodule

// File: rtl/pip_window_chk.sv
module pip_window_chk (
  input logic       clk,
  input logic       rstN,
  input logic       hsync,
  input logic       dispEn,
  input logic       fieldFix,
  input logic       fieldFixVal,
  input logic [7:0] hPos,
  input logic       pipSwitch,
  input logic       borderSel,
  input logic       bgSel,
  input logic       fieldOdd
);

  // R5
  sw_needs_disp_chk: assert property (@(posedge clk) disable iff (!rstN)
    pipSwitch |-> $past(dispEn));

  // R6
  border_in_win_chk: assert property (@(posedge clk) disable iff (!rstN)
    borderSel |-> pipSwitch);

  // R7
  bg_not_border_chk: assert property (@(posedge clk) disable iff (!rstN)
    bgSel |-> (pipSwitch && !borderSel));

  // R7
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({borderSel, bgSel}));

  // R10
  field_forced_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(fieldFix)) |-> (fieldOdd == $past(fieldFixVal)));

  // R11
  line_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hsync && !$past(hsync) && hPos != 8'd0) |=> ##1 !pipSwitch);

endmodule

bind pip_window_gen pip_window_chk u_chk (
  .clk(clk), .rstN(rstN), .hsync(hsync), .dispEn(dispEn),
  .fieldFix(fieldFix), .fieldFixVal(fieldFixVal), .hPos(hPos),
  .pipSwitch(pipSwitch), .borderSel(borderSel), .bgSel(bgSel),
  .fieldOdd(fieldOdd)
);

// File: tb/pip_window_gen_tb.sv
module pip_window_gen_tb;

  localparam int L   = 40;  // clocks per line
  localparam int W9  = 9;
  localparam int W16 = 6;
  localparam int H9  = 5;
  localparam int H16 = 3;
  localparam int F50 = 21;  // lines per field that count as 50 Hz

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hsync = 1'b0, vsync = 1'b0;
  logic dispEn = 0, frameEn = 0, bgEn = 0, sizeV = 0, sizeH = 0;
  logic posMode = 0, invField = 0, fieldFix = 0, fieldFixVal = 0;
  logic [7:0] vPos = 8'd0, hPos = 8'd0;
  logic pipSwitch, borderSel, bgSel, fieldOdd;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  string curTag = "";
  int lastN = 0;     // lines of previous field (excluding its sync line)
  int vS = 0;        // expected vertical origin for the current field
  int lastVAt = 0;

  always #10 clk = ~clk;

  pip_window_gen #(
    .WIN_W9(W9), .WIN_W16(W16), .WIN_H9(H9), .WIN_H16(H16),
    .FIELD50_MIN(F50)
  ) u_dut (
    .clk(clk), .rstN(rstN), .hsync(hsync), .vsync(vsync),
    .dispEn(dispEn), .frameEn(frameEn), .bgEn(bgEn), .sizeV(sizeV),
    .sizeH(sizeH), .posMode(posMode), .invField(invField),
    .fieldFix(fieldFix), .fieldFixVal(fieldFixVal), .vPos(vPos),
    .hPos(hPos), .pipSwitch(pipSwitch), .borderSel(borderSel),
    .bgSel(bgSel), .fieldOdd(fieldOdd)
  );

  task automatic check1(input string tag, input logic act, input logic exp,
                        input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic checkPix(input int p, input int ln);
    int w, h;
    bit sw, bd, bg;
    w  = sizeH ? W16 : W9;
    h  = sizeV ? H16 : H9;
    sw = dispEn && ln >= vS && ln < vS + h && p >= hPos && p < hPos + w;
    bd = sw && frameEn &&
         (ln == vS || ln == vS + h - 1 || p < hPos + 2 || p >= hPos + w - 2);
    bg = sw && bgEn && !bd;
    checks++;
    if (pipSwitch !== sw || borderSel !== bd || bgSel !== bg) begin
      errors++;
      $display("FAIL %s line %0d pix %0d: actual sw/bd/bg=%0b%0b%0b expected=%0b%0b%0b",
               curTag, ln, p, pipSwitch, borderSel, bgSel, sw, bd, bg);
    end
  endtask

  // One line of L clocks; called at a falling edge
  task automatic runLine(input int ln, input bit chk, input int vAt);
    hsync = 1'b1;
    for (int m = 0; m < L; m++) begin
      @(negedge clk);
      if (m == 0) hsync = 1'b0;
      if (vAt >= 0 && m == vAt) vsync = 1'b1;
      if (vAt >= 0 && m == vAt + 1) vsync = 1'b0;
      if (chk && m >= 1) checkPix(m - 1, ln);
    end
  endtask

  // Sync line carrying the vertical edge, then n checked lines
  task automatic runField(input int n, input int vAt, input bit chk);
    bit fifty;
    fifty = (lastN + 1) >= F50;
    vS = (posMode && fifty) ? (vPos * 12) / 10 : vPos;
    lastVAt = vAt;
    runLine(0, 1'b0, vAt);
    for (int i = 1; i <= n; i++) runLine(i, chk, -1);
    lastN = n;
  endtask

  task automatic t_reset();
    check1("R1", pipSwitch, 1'b0, "pipSwitch in reset");
    check1("R1", borderSel, 1'b0, "borderSel in reset");
    check1("R1", bgSel, 1'b0, "bgSel in reset");
    check1("R1", fieldOdd, 1'b0, "fieldOdd in reset");
  endtask

  task automatic t_basic();
    curTag = "R2 R3 R4 one-ninth";
    dispEn = 1; sizeV = 0; sizeH = 0; hPos = 8'd3; vPos = 8'd2;
    runField(12, 5, 1'b1);
  endtask

  task automatic t_small();
    curTag = "R3 R4 one-sixteenth";
    sizeV = 1; sizeH = 1; hPos = 8'd10; vPos = 8'd4;
    runField(12, 5, 1'b1);
    curTag = "R3 R4 mixed sizes";
    sizeV = 0; sizeH = 1;
    runField(12, 5, 1'b1);
  endtask

  task automatic t_border();
    curTag = "R6 R7 border and fill";
    sizeV = 0; sizeH = 0; hPos = 8'd3; vPos = 8'd2; frameEn = 1; bgEn = 1;
    runField(12, 5, 1'b1);
    curTag = "R7 fill without border";
    frameEn = 0;
    runField(12, 5, 1'b1);
  endtask

  task automatic t_off();
    curTag = "R5 display off";
    dispEn = 0; frameEn = 1; bgEn = 1;
    runField(12, 5, 1'b1);
    dispEn = 1; frameEn = 0; bgEn = 0;
  endtask

  task automatic t_fifty();
    curTag = "R8 50Hz";
    posMode = 1; vPos = 8'd5;
    runField(25, 5, 1'b1);   // previous field short: origin 5
    runField(25, 5, 1'b1);   // previous field long: origin 6
    vPos = 8'd10;
    runField(25, 5, 1'b1);   // origin 12
    posMode = 0;
    runField(25, 5, 1'b1);   // origin 10
    posMode = 1; vPos = 8'd5;
    runField(15, 5, 1'b1);   // previous long: origin 6
    runField(15, 5, 1'b1);   // previous short: origin 5
    posMode = 0;
  endtask

  task automatic t_parity();
    runField(15, 5, 1'b0);
    check1("R9", fieldOdd, 1'b1, "edge early in line");
    runField(15, 30, 1'b0);
    check1("R9", fieldOdd, 1'b0, "edge late in line");
    @(negedge clk); invField = 1; @(negedge clk); @(negedge clk);
    check1("R10", fieldOdd, 1'b1, "inverted parity");
    fieldFix = 1; fieldFixVal = 0; @(negedge clk); @(negedge clk);
    check1("R10", fieldOdd, 1'b0, "forced low");
    fieldFixVal = 1; @(negedge clk); @(negedge clk);
    check1("R10", fieldOdd, 1'b1, "forced high");
    fieldFix = 0; invField = 0; @(negedge clk); @(negedge clk);
    check1("R9", fieldOdd, 1'b0, "released to measured");
  endtask

  task automatic t_clip();
    curTag = "R11 clipped at line and field end";
    sizeV = 0; sizeH = 0; hPos = 8'd35; vPos = 8'd10;
    runField(12, 5, 1'b1);
    runField(12, 5, 1'b1);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    runField(15, 5, 1'b0);
    runField(15, 5, 1'b0);
    t_basic();
    t_small();
    t_border();
    t_off();
    t_fifty();
    t_parity();
    t_clip();
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule